// File: doc/BRIEF.md
# Event-Code Trigger Generator

This block sits at the receiving end of a timing network. Sixteen-bit event codes arrive as serial frames, one bit per qualified reference-clock cycle. Each accepted code is compared against a small set of programmable match entries. Every entry owns one trigger output. On a hit, that channel counts a programmable number of reference-clock ticks and then drives a pulse of programmable width. Every subsystem counts in ticks of the same shared reference clock, so receivers that are far apart fire together.

Each accepted event is also recorded in a readable event register. The register holds the code and the value of a free-running 32-bit timestamp. Malformed frames are discarded and tallied. A register port sets the match codes, delays and widths. The whole path from a source event to its trigger has to fit within 5 microseconds, so the delay a channel accepts is capped at a parameterised tick budget.

Top module: `edt_event_trigger`

## Requirements
- R1: A frame is a 1 start bit, then 16 data bits with the most significant first, then a parity bit chosen so that data plus parity hold an even number of ones, then a 0 stop bit. Bits count only in cycles with `ser_vld` high. A 0 on the idle line starts nothing. An accepted frame's code is what the event register reads back.
- R2: A frame with wrong parity or a stop bit of 1 produces no event and no trigger. It increments the 16-bit drop counter, read at address 4*NCH+2, which saturates at 0xFFFF.
- R3: When an accepted code equals channel c's match code and the channel delay is D, `trig[c]` is first high in the cycle after the (D+1)th rising edge that follows the edge sampling the stop bit. So D=0 fires on the cycle after the event is registered.
- R4: The trigger stays high for W cycles, where W is the channel width. A width of 0 gives a one-cycle pulse.
- R5: A code that matches no channel leaves every trigger output low.
- R6: A match that arrives while a channel is still counting its delay restarts the count from the full delay. It also sets that channel's sticky retrigger flag, bit 0 at address 4c+3. Any write to that address clears the flag.
- R7: A delay write larger than BUDGET_TICKS is stored, read back and used as BUDGET_TICKS.
- R8: Each accepted event latches its code into address 4*NCH and the free-running 32-bit timestamp into 4*NCH+1. Two events whose stop bits are sampled N edges apart have timestamps N apart. The live timestamp reads at 4*NCH+3.
- R9: After a synchronous active-low reset, all triggers are low and all readable registers read 0.
- R10: Channel c's match code sits at address 4c+0 in bits 15:0, its delay at 4c+1 in bits 23:0, and its width at 4c+2 in bits 15:0. Written values read back combinationally on `reg_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_vld | input | 1 | Qualifies `ser_bit` in this cycle |
| ser_bit | input | 1 | Serial event-frame bit |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| trig | output | 4 | Trigger outputs, one per channel |

## Verification
The bench builds the block with four channels, 16-bit codes, 24-bit delays and 16-bit widths, matching the deployed shape. It lowers BUDGET_TICKS to 60 so that a clamped delay can both be read back and actually fire inside a short run. The delays are chosen to be distinct and small (0, 2, 5, 17), so the rise cycle of every channel can be told apart. A delay of 30 leaves room for a second back-to-back frame, one frame length later, to land while the first count is still running.

// File: rtl/edt_pkg.sv
// Package: shared state encodings for the event-code trigger generator.
// Assumes: the consumers are synthesizable modules with no further types.
package edt_pkg;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_DATA,
        RX_PAR,
        RX_STOP
    } rx_state_e;

    typedef enum logic [1:0] {
        CH_IDLE,
        CH_WAIT,
        CH_PULSE
    } ch_state_e;

    // Field selectors inside one channel's four-word window.
    localparam logic [1:0] FLD_CODE   = 2'd0;
    localparam logic [1:0] FLD_DELAY  = 2'd1;
    localparam logic [1:0] FLD_WIDTH  = 2'd2;
    localparam logic [1:0] FLD_STATUS = 2'd3;

endpackage

// File: rtl/edt_frame_rx.sv
// Module: serial event-frame receiver.
// Does: assembles start(1) + CODE_W data bits (MSB first) + even parity + stop(0),
//       emits a one-cycle event strobe with the code, counts rejected frames.
// Assumes: bits are qualified by bit_vld; the idle line carries 0.
module edt_frame_rx
    import edt_pkg::*;
#(
    parameter int CODE_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_vld,
    input  logic              bit_in,
    output logic              ev_vld,
    output logic [CODE_W-1:0] ev_code,
    output logic [CNT_W-1:0]  drop_cnt
);

    localparam int BC_W = $clog2(CODE_W);

    rx_state_e         st;
    logic [BC_W-1:0]   bcnt;
    logic [CODE_W-1:0] shift;
    logic              par_q;

    // Frame sequencer: shifts data, checks parity and stop, strobes or drops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= RX_IDLE;
            bcnt     <= '0;
            shift    <= '0;
            par_q    <= 1'b0;
            ev_vld   <= 1'b0;
            ev_code  <= '0;
            drop_cnt <= '0;
        end else begin
            ev_vld <= 1'b0;
            if (bit_vld) begin
                case (st)
                    RX_IDLE: begin
                        if (bit_in) begin
                            st   <= RX_DATA;
                            bcnt <= '0;
                        end
                    end
                    RX_DATA: begin
                        shift <= {shift[CODE_W-2:0], bit_in};
                        bcnt  <= bcnt + 1'b1;
                        if (bcnt == BC_W'(CODE_W - 1)) st <= RX_PAR;
                    end
                    RX_PAR: begin
                        par_q <= bit_in;
                        st    <= RX_STOP;
                    end
                    default: begin
                        if (((^shift) ^ par_q) == 1'b0 && bit_in == 1'b0) begin
                            ev_vld  <= 1'b1;
                            ev_code <= shift;
                        end else if (drop_cnt != '1) begin
                            drop_cnt <= drop_cnt + 1'b1;
                        end
                        st <= RX_IDLE;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/edt_trig_chan.sv
// Module: one trigger channel (match, delay countdown, pulse stretcher).
// Does: on a code hit waits dly ticks, then holds trig for max(wid,1) ticks;
//       a hit during the wait restarts it and reports a retrigger.
// Assumes: dly already clamped by the register file.
module edt_trig_chan
    import edt_pkg::*;
#(
    parameter int CODE_W  = 16,
    parameter int DELAY_W = 24,
    parameter int WIDTH_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ev_vld,
    input  logic [CODE_W-1:0]  ev_code,
    input  logic [CODE_W-1:0]  match,
    input  logic [DELAY_W-1:0] dly,
    input  logic [WIDTH_W-1:0] wid,
    output logic               trig,
    output logic               retrig
);

    ch_state_e          st;
    logic [DELAY_W-1:0] dcnt;
    logic [WIDTH_W-1:0] wcnt;
    logic               hit;
    logic [WIDTH_W-1:0] wload;

    // Hit detection and pulse length with zero promoted to one.
    always_comb begin
        hit    = ev_vld && (ev_code == match);
        wload  = (wid == '0) ? WIDTH_W'(1) : wid;
        retrig = hit && (st == CH_WAIT);
        trig   = (st == CH_PULSE);
    end

    // Channel sequencer: idle -> wait -> pulse, restart on every hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= CH_IDLE;
            dcnt <= '0;
            wcnt <= '0;
        end else if (hit) begin
            if (dly == '0) begin
                st   <= CH_PULSE;
                wcnt <= wload;
            end else begin
                st   <= CH_WAIT;
                dcnt <= dly;
            end
        end else begin
            case (st)
                CH_WAIT: begin
                    if (dcnt == DELAY_W'(1)) begin
                        st   <= CH_PULSE;
                        wcnt <= wload;
                    end else begin
                        dcnt <= dcnt - 1'b1;
                    end
                end
                CH_PULSE: begin
                    if (wcnt == WIDTH_W'(1)) st <= CH_IDLE;
                    else                     wcnt <= wcnt - 1'b1;
                end
                default: st <= CH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/edt_event_trigger.sv
// Module: event-code trigger generator top.
// Does: receives framed codes, keeps the channel register file, a free-running
//       timestamp and the last-event register, and drives NCH triggers.
// Assumes: NCH*4+4 addresses fit in ADDR_W; BUDGET_TICKS fits in DELAY_W.
module edt_event_trigger
    import edt_pkg::*;
#(
    parameter int NCH          = 4,
    parameter int CODE_W       = 16,
    parameter int DELAY_W      = 24,
    parameter int WIDTH_W      = 16,
    parameter int TS_W         = 32,
    parameter int CNT_W        = 16,
    parameter int ADDR_W       = 5,
    parameter int DATA_W       = 32,
    parameter int BUDGET_TICKS = 500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_vld,
    input  logic              ser_bit,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [NCH-1:0]    trig
);

    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;
    localparam logic [ADDR_W-1:0] A_EV_CODE = ADDR_W'(NCH * 4);
    localparam logic [ADDR_W-1:0] A_EV_TS   = ADDR_W'(NCH * 4 + 1);
    localparam logic [ADDR_W-1:0] A_DROP    = ADDR_W'(NCH * 4 + 2);
    localparam logic [ADDR_W-1:0] A_TS_LIVE = ADDR_W'(NCH * 4 + 3);
    localparam logic [DELAY_W-1:0] BUDGET_D = DELAY_W'(BUDGET_TICKS);

    logic                ev_vld;
    logic [CODE_W-1:0]   ev_code;
    logic [CNT_W-1:0]    drop_cnt;
    logic [CODE_W-1:0]   code_q [NCH];
    logic [DELAY_W-1:0]  dly_q  [NCH];
    logic [WIDTH_W-1:0]  wid_q  [NCH];
    logic [NCH-1:0]      retrig_q;
    logic [NCH-1:0]      retrig_p;
    logic [TS_W-1:0]     ts_cnt;
    logic [CODE_W-1:0]   ev_code_q;
    logic [TS_W-1:0]     ev_ts_q;
    logic                is_chan;
    logic [CH_W-1:0]     sel;
    logic [1:0]          fld;
    logic [DELAY_W-1:0]  dly_wr;

    edt_frame_rx #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .bit_vld(ser_vld), .bit_in(ser_bit),
        .ev_vld(ev_vld), .ev_code(ev_code), .drop_cnt(drop_cnt)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        edt_trig_chan #(.CODE_W(CODE_W), .DELAY_W(DELAY_W), .WIDTH_W(WIDTH_W)) u_ch (
            .clk(clk), .rst_n(rst_n), .ev_vld(ev_vld), .ev_code(ev_code),
            .match(code_q[c]), .dly(dly_q[c]), .wid(wid_q[c]),
            .trig(trig[c]), .retrig(retrig_p[c])
        );
    end

    // Address decode and delay clamp to the latency budget.
    always_comb begin
        is_chan = (reg_addr < ADDR_W'(NCH * 4));
        sel     = reg_addr[CH_W+1:2];
        fld     = reg_addr[1:0];
        dly_wr  = (reg_wdata > DATA_W'(BUDGET_TICKS)) ? BUDGET_D : reg_wdata[DELAY_W-1:0];
    end

    // Channel register file writes and sticky retrigger flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NCH; c++) begin
                code_q[c] <= '0;
                dly_q[c]  <= '0;
                wid_q[c]  <= '0;
            end
            retrig_q <= '0;
        end else begin
            for (int c = 0; c < NCH; c++) begin
                if (reg_we && is_chan && sel == CH_W'(c)) begin
                    case (fld)
                        FLD_CODE:  code_q[c] <= reg_wdata[CODE_W-1:0];
                        FLD_DELAY: dly_q[c]  <= dly_wr;
                        FLD_WIDTH: wid_q[c]  <= reg_wdata[WIDTH_W-1:0];
                        default:   retrig_q[c] <= 1'b0;
                    endcase
                end
                if (retrig_p[c]) retrig_q[c] <= 1'b1;
            end
        end
    end

    // Free-running timestamp and last-event capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ts_cnt    <= '0;
            ev_code_q <= '0;
            ev_ts_q   <= '0;
        end else begin
            ts_cnt <= ts_cnt + 1'b1;
            if (ev_vld) begin
                ev_code_q <= ev_code;
                ev_ts_q   <= ts_cnt;
            end
        end
    end

    // Combinational register read mux.
    always_comb begin
        reg_rdata = '0;
        if (is_chan) begin
            case (fld)
                FLD_CODE:  reg_rdata[CODE_W-1:0]  = code_q[sel];
                FLD_DELAY: reg_rdata[DELAY_W-1:0] = dly_q[sel];
                FLD_WIDTH: reg_rdata[WIDTH_W-1:0] = wid_q[sel];
                default:   reg_rdata[0]           = retrig_q[sel];
            endcase
        end else if (reg_addr == A_EV_CODE) begin
            reg_rdata[CODE_W-1:0] = ev_code_q;
        end else if (reg_addr == A_EV_TS) begin
            reg_rdata[TS_W-1:0] = ev_ts_q;
        end else if (reg_addr == A_DROP) begin
            reg_rdata[CNT_W-1:0] = drop_cnt;
        end else if (reg_addr == A_TS_LIVE) begin
            reg_rdata[TS_W-1:0] = ts_cnt;
        end
    end

endmodule

// File: rtl/edt_event_trigger_chk.sv
// Module: assertion checker for the event-code trigger generator.
// Does: checks reset quiet, frame strobe spacing, drop counting, delay budget
//       and zero-delay firing. Assumes: bound to edt_event_trigger.
module edt_event_trigger_chk #(
    parameter int NCH          = 4,
    parameter int CODE_W       = 16,
    parameter int DELAY_W      = 24,
    parameter int CNT_W        = 16,
    parameter int BUDGET_TICKS = 500
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NCH-1:0]     trig,
    input logic               ev_vld,
    input logic [CODE_W-1:0]  ev_code,
    input logic [CNT_W-1:0]   drop_cnt,
    input logic [CODE_W-1:0]  code_q [NCH],
    input logic [DELAY_W-1:0] dly_q  [NCH]
);

    // R9: a reset cycle leaves every trigger low.
    p_quiet_reset_r9: assert property (@(posedge clk) !rst_n |=> trig == '0);

    // R1: an event strobe lasts one cycle (frames are far longer).
    p_event_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ev_vld |=> !ev_vld);

    // R2: the drop counter never decreases outside reset.
    p_drop_monotonic_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> drop_cnt >= $past(drop_cnt));

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        // R7: a stored delay never exceeds the budget.
        p_delay_budget_r7: assert property (@(posedge clk) disable iff (!rst_n)
            dly_q[c] <= DELAY_W'(BUDGET_TICKS));

        // R3: a hit with zero delay raises the trigger on the next cycle.
        p_zero_delay_fire_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (ev_vld && ev_code == code_q[c] && dly_q[c] == '0) |=> trig[c]);
    end

endmodule

bind edt_event_trigger edt_event_trigger_chk #(
    .NCH(NCH), .CODE_W(CODE_W), .DELAY_W(DELAY_W), .CNT_W(CNT_W),
    .BUDGET_TICKS(BUDGET_TICKS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .trig(trig), .ev_vld(ev_vld), .ev_code(ev_code),
    .drop_cnt(drop_cnt), .code_q(code_q), .dly_q(dly_q)
);

// File: tb/edt_event_trigger_bench.sv
// Bench: vector table for code matching, then directed tests for reset,
// rejected frames, retrigger, delay clamp and timestamps.
module edt_event_trigger_bench;

    localparam int BUDGET = 60;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_vld = 1'b0;
    logic        ser_bit = 1'b0;
    logic        reg_we = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  trig;

    int checks = 0;
    int fails  = 0;
    bit seen_trig;

    edt_event_trigger #(.BUDGET_TICKS(BUDGET)) u_edt_event_trigger (
        .clk(clk), .rst_n(rst_n), .ser_vld(ser_vld), .ser_bit(ser_bit),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .trig(trig)
    );

    always #5 clk = ~clk;

    // Vector: code[34:19], channel[18:16] (4 = none), rise[15:8], width[7:0].
    localparam int NV = 6;
    localparam logic [34:0] VEC [NV] = '{
        {16'h1234, 3'd0, 8'd1,  8'd3},
        {16'hA5F0, 3'd1, 8'd6,  8'd1},
        {16'h0001, 3'd2, 8'd18, 8'd1},
        {16'hFFFF, 3'd3, 8'd3,  8'd4},
        {16'h1235, 3'd4, 8'd0,  8'd0},
        {16'h0000, 3'd4, 8'd0,  8'd0}
    };

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // Drives one frame; returns just after the edge that samples the stop bit.
    task automatic send_frame(input logic [15:0] code, input bit bad_par, input bit stop_v);
        logic [18:0] bits;
        bits = {1'b1, code, (^code) ^ bad_par, stop_v};
        seen_trig = 1'b0;
        for (int i = 18; i >= 0; i--) begin
            @(negedge clk);
            ser_vld = 1'b1; ser_bit = bits[i];
            if (trig != '0) seen_trig = 1'b1;
        end
        @(posedge clk); #1;
        ser_vld = 1'b0; ser_bit = 1'b0;
    endtask

    // Counts edges until a trigger is seen, then the pulse length.
    task automatic measure(input int win, output int rise, output int width, output logic [3:0] which);
        rise = 0; width = 0; which = '0;
        for (int i = 1; i <= win; i++) begin
            @(posedge clk); #1;
            if (trig != '0) begin rise = i; which = trig; break; end
        end
        if (rise > 0) begin
            width = 1;
            while (width < 200) begin
                @(posedge clk); #1;
                if (trig != '0) width++; else break;
            end
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        logic [31:0] d;
        int rise, width;
        logic [3:0] which;
        logic [31:0] ts1, ts2;

        repeat (4) @(posedge clk);
        #1;
        // R9: reset state.
        chk(trig == '0, "R9 trig in reset", trig, 0);
        rst_n = 1'b1;
        rd(5'd0, d);  chk(d == 0, "R9 code0", d, 0);
        rd(5'd1, d);  chk(d == 0, "R9 delay0", d, 0);
        rd(5'd16, d); chk(d == 0, "R9 event code", d, 0);
        rd(5'd18, d); chk(d == 0, "R9 drop count", d, 0);

        // R10: program channels and read back.
        wr(5'd0, 32'h1234); wr(5'd1, 0);  wr(5'd2, 3);
        wr(5'd4, 32'hA5F0); wr(5'd5, 5);  wr(5'd6, 1);
        wr(5'd8, 32'h0001); wr(5'd9, 17); wr(5'd10, 0);
        wr(5'd12, 32'hFFFF); wr(5'd13, 2); wr(5'd14, 4);
        rd(5'd4, d);  chk(d == 32'hA5F0, "R10 code readback", d, 32'hA5F0);
        rd(5'd9, d);  chk(d == 17, "R10 delay readback", d, 17);
        rd(5'd14, d); chk(d == 4, "R10 width readback", d, 4);

        // R1 R3 R4 R5: table of codes.
        for (int v = 0; v < NV; v++) begin
            logic [15:0] code;
            int ch, er, ew;
            code = VEC[v][34:19]; ch = int'(VEC[v][18:16]);
            er = int'(VEC[v][15:8]); ew = int'(VEC[v][7:0]);
            send_frame(code, 1'b0, 1'b0);
            measure(40, rise, width, which);
            if (ch == 4) begin
                chk(rise == 0, "R5 no trigger for unmatched code", rise, 0);
            end else begin
                chk(which == (4'b1 << ch), "R3 channel select", which, 4'b1 << ch);
                chk(rise == er, "R3 rise cycle", rise, er);
                chk(width == ew, "R4 pulse width", width, ew);
            end
            rd(5'd16, d);
            chk(d == {16'h0, code}, "R1 event code MSB first", d, code);
        end

        // R2: bad parity, then bad stop bit.
        send_frame(16'h1234, 1'b1, 1'b0);
        measure(30, rise, width, which);
        chk(rise == 0, "R2 bad parity no trigger", rise, 0);
        rd(5'd18, d); chk(d == 1, "R2 drop after parity error", d, 1);
        send_frame(16'h1234, 1'b0, 1'b1);
        measure(30, rise, width, which);
        chk(rise == 0, "R2 bad stop no trigger", rise, 0);
        rd(5'd18, d); chk(d == 2, "R2 drop after stop error", d, 2);

        // R6: second hit during the wait restarts it.
        wr(5'd5, 30);
        rd(5'd7, d); chk(d == 0, "R6 flag clear before", d, 0);
        send_frame(16'hA5F0, 1'b0, 1'b0);
        send_frame(16'hA5F0, 1'b0, 1'b0);
        chk(!seen_trig, "R6 no early fire during restart", seen_trig, 0);
        measure(60, rise, width, which);
        chk(rise == 31, "R6 restarted delay", rise, 31);
        rd(5'd7, d); chk(d == 1, "R6 retrigger flag set", d, 1);
        wr(5'd7, 0);
        rd(5'd7, d); chk(d == 0, "R6 retrigger flag cleared", d, 0);

        // R7: over-budget delay clamps and fires at the budget.
        wr(5'd13, 1000);
        rd(5'd13, d); chk(d == BUDGET, "R7 delay clamped", d, BUDGET);
        send_frame(16'hFFFF, 1'b0, 1'b0);
        measure(100, rise, width, which);
        chk(rise == BUDGET + 1, "R7 clamped delay fires", rise, BUDGET + 1);

        // R8: timestamp spacing between two events.
        send_frame(16'h1234, 1'b0, 1'b0);
        repeat (2) @(posedge clk);
        #1 reg_addr = 5'd17;
        #1 ts1 = reg_rdata;
        repeat (8) @(posedge clk);
        send_frame(16'hA5F0, 1'b0, 1'b0);
        repeat (2) @(posedge clk);
        rd(5'd17, ts2);
        chk(ts2 - ts1 == 29, "R8 timestamp spacing", ts2 - ts1, 29);
        rd(5'd16, d); chk(d == 32'hA5F0, "R8 latched code", d, 32'hA5F0);
        rd(5'd19, d); chk(d > ts2, "R8 live timestamp runs", d, ts2);

        repeat (80) @(posedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule